// File: doc/BRIEF.md
# Packet Timestamp Capture Latch

This block holds the time value at which a qualifying packet event took place, one capture channel per direction. Channel 0 serves received packets and channel 1 serves transmitted packets. The local time counter arrives on an input bus. A per-channel event strobe arrives already qualified by the packet classifier. Software configures and drains each channel through a small register port. Each channel has a control word, a low stamp word and a high stamp word.

Once a channel has taken a stamp, it stays locked until software reads the high stamp word. Events that arrive in the meantime are dropped. Each stored stamp therefore belongs to exactly one packet. The usual drain order is to poll the control word until the valid flag is set, read the low word, and then read the high word, which releases the channel for the next packet.

Top module: `pkt_stamp_latch`

## Requirements
- R1: After reset, every channel is disabled and holds no stamp. `pending` is all zeros and `reg_rdata` reads zero.
- R2: The control word has the enable flag at bit 0, which is read/write, and the valid flag at bit 1, which is read-only. All other bits read zero. A write to bit 1 has no effect on the valid flag.
- R3: On a clock edge where a channel is enabled, its event strobe is high and its valid flag is clear, the channel stores `time_in` from that edge. Its valid flag is set from the next cycle on.
- R4: While a channel's valid flag is set, its events are ignored and the stored stamp does not change.
- R5: A read of a channel's high stamp word clears that channel's valid flag at the same edge. The returned data is the stored stamp's upper half.
- R6: A read of the low stamp word returns stamp bits 31:0 and leaves the valid flag set.
- R7: If a high-word read and an event of the same channel fall on the same edge, the read wins. The event is dropped and the channel is left empty.
- R8: While a channel's enable flag is clear, its events are ignored. Clearing the enable flag leaves a pending stamp and its valid flag in place.
- R9: The two channels are independent. Channel 0 (receive) occupies addresses 0 to 2 and channel 1 (transmit) occupies addresses 4 to 6. Activity on one channel never changes the other.
- R10: Address bits [1:0] select the word: 0 is control, 1 is the low stamp, 2 is the high stamp, and 3 reads zero. Addresses of channels that do not exist also read zero. Read data appears on `reg_rdata` in the cycle after `reg_rd` and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| time_in | input | 64 | Current time value from the time counter |
| evt | input | 2 | Qualified packet event per channel (bit 0 receive, bit 1 transmit) |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register address: channel in [3:2], word in [1:0] |
| reg_wdata | input | 32 | Write data, of which bit 0 is used |
| reg_rdata | output | 32 | Registered read data |
| pending | output | 2 | Valid flag of each channel |

## Verification
The assertions assume that `time_in` and `evt` are settled before each rising edge. They also assume that a single register access names one address per cycle, so a high-word read decodes to exactly one channel. The bench drives every input half a period away from the rising edge. It draws addresses only from the defined space plus one channel number beyond it. Events, reads and writes are left free to coincide on the same edge, so the read-over-event and write-during-capture cases come up often.

// File: rtl/pkt_stamp_pkg.sv
package pkt_stamp_pkg;
   typedef enum logic [1:0] {
      SEL_CTRL = 2'd0,
      SEL_LO   = 2'd1,
      SEL_HI   = 2'd2,
      SEL_RSVD = 2'd3
   } stamp_sel_e;

   localparam int CTRL_EN_BIT    = 0;
   localparam int CTRL_VALID_BIT = 1;
   localparam int SEL_W          = 2;
endpackage

// File: rtl/stamp_addr_dec.sv
module stamp_addr_dec
   import pkt_stamp_pkg::*;
#(
   parameter int NUM_CH = 2,
   parameter int ADDR_W = 4
) (
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [ADDR_W-1:0] reg_addr,
   output logic [NUM_CH-1:0] wr_ctrl,
   output logic [NUM_CH-1:0] rd_hi
);
   localparam int CH_W = ADDR_W - SEL_W;

   logic [CH_W-1:0] ch_idx;
   stamp_sel_e      sel;

   assign ch_idx = reg_addr[ADDR_W-1:SEL_W];
   assign sel    = stamp_sel_e'(reg_addr[SEL_W-1:0]);

   for (genvar c = 0; c < NUM_CH; c++) begin : g_dec
      assign wr_ctrl[c] = reg_wr && (ch_idx == CH_W'(c)) && (sel == SEL_CTRL);
      assign rd_hi[c]   = reg_rd && (ch_idx == CH_W'(c)) && (sel == SEL_HI);
   end
endmodule

// File: rtl/stamp_chan.sv
module stamp_chan #(
   parameter int TIME_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TIME_W-1:0] time_in,
   input  logic              evt,
   input  logic              wr_ctrl,
   input  logic              wr_en_val,
   input  logic              rd_hi,
   output logic              en,
   output logic              valid,
   output logic [TIME_W-1:0] stamp
);
   logic take;

   // the high-word read has priority, so the event is lost on that edge
   assign take = en && evt && !valid && !rd_hi;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en    <= 1'b0;
         valid <= 1'b0;
         stamp <= '0;
      end else begin
         if (wr_ctrl) en <= wr_en_val;
         if (rd_hi) begin
            valid <= 1'b0;
         end else if (take) begin
            valid <= 1'b1;
            stamp <= time_in;
         end
      end
   end
endmodule

// File: rtl/stamp_rdmux.sv
module stamp_rdmux
   import pkt_stamp_pkg::*;
#(
   parameter int TIME_W = 64,
   parameter int WORD_W = 32,
   parameter int NUM_CH = 2,
   parameter int ADDR_W = 4
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           reg_rd,
   input  logic [ADDR_W-1:0]              reg_addr,
   input  logic [NUM_CH-1:0]              en_vec,
   input  logic [NUM_CH-1:0]              valid_vec,
   input  logic [NUM_CH-1:0][TIME_W-1:0]  stamps,
   output logic [WORD_W-1:0]              reg_rdata
);
   localparam int CH_W = ADDR_W - SEL_W;

   logic [CH_W-1:0]   ch_idx;
   stamp_sel_e        sel;
   logic [WORD_W-1:0] word;

   assign ch_idx = reg_addr[ADDR_W-1:SEL_W];
   assign sel    = stamp_sel_e'(reg_addr[SEL_W-1:0]);

   always_comb begin
      word = '0;
      for (int c = 0; c < NUM_CH; c++) begin
         if (ch_idx == CH_W'(c)) begin
            unique case (sel)
               SEL_CTRL: begin
                  word[CTRL_EN_BIT]    = en_vec[c];
                  word[CTRL_VALID_BIT] = valid_vec[c];
               end
               SEL_LO:   word = stamps[c][WORD_W-1:0];
               SEL_HI:   word = WORD_W'(stamps[c] >> WORD_W);
               SEL_RSVD: word = '0;
            endcase
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      reg_rdata <= '0;
      else if (reg_rd) reg_rdata <= word;
   end
endmodule

// File: rtl/pkt_stamp_latch.sv
module pkt_stamp_latch
   import pkt_stamp_pkg::*;
#(
   parameter int TIME_W = 64,
   parameter int WORD_W = 32,
   parameter int NUM_CH = 2,
   parameter int ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TIME_W-1:0] time_in,
   input  logic [NUM_CH-1:0] evt,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [WORD_W-1:0] reg_wdata,
   output logic [WORD_W-1:0] reg_rdata,
   output logic [NUM_CH-1:0] pending
);
   localparam int CH_W = ADDR_W - SEL_W;

   if (TIME_W <= WORD_W || TIME_W > 2 * WORD_W) begin : g_bad_time_w
      $error("TIME_W must span more than one and at most two words");
   end
   if (CH_W < 1 || NUM_CH < 1 || NUM_CH > (1 << CH_W)) begin : g_bad_ch
      $error("NUM_CH does not fit the channel field of reg_addr");
   end
   if (WORD_W < 2) begin : g_bad_word
      $error("WORD_W must hold the control flags");
   end

   logic [NUM_CH-1:0]             wr_ctrl;
   logic [NUM_CH-1:0]             rd_hi;
   logic [NUM_CH-1:0]             en_vec;
   logic [NUM_CH-1:0]             valid_vec;
   logic [NUM_CH-1:0][TIME_W-1:0] stamps;
   logic                          unused_wbits;

   assign unused_wbits = ^reg_wdata[WORD_W-1:1];

   stamp_addr_dec #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dec (
      .reg_wr  (reg_wr),
      .reg_rd  (reg_rd),
      .reg_addr(reg_addr),
      .wr_ctrl (wr_ctrl),
      .rd_hi   (rd_hi)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      stamp_chan #(.TIME_W(TIME_W)) u_chan (
         .clk      (clk),
         .rst_n    (rst_n),
         .time_in  (time_in),
         .evt      (evt[c]),
         .wr_ctrl  (wr_ctrl[c]),
         .wr_en_val(reg_wdata[CTRL_EN_BIT]),
         .rd_hi    (rd_hi[c]),
         .en       (en_vec[c]),
         .valid    (valid_vec[c]),
         .stamp    (stamps[c])
      );
   end

   stamp_rdmux #(
      .TIME_W(TIME_W), .WORD_W(WORD_W), .NUM_CH(NUM_CH), .ADDR_W(ADDR_W)
   ) u_rd (
      .clk      (clk),
      .rst_n    (rst_n),
      .reg_rd   (reg_rd),
      .reg_addr (reg_addr),
      .en_vec   (en_vec),
      .valid_vec(valid_vec),
      .stamps   (stamps),
      .reg_rdata(reg_rdata)
   );

   assign pending = valid_vec;
endmodule

// File: rtl/pkt_stamp_latch_chk.sv
module pkt_stamp_latch_chk #(
   parameter int TIME_W = 64,
   parameter int WORD_W = 32,
   parameter int NUM_CH = 2,
   parameter int ADDR_W = 4
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic [TIME_W-1:0]             time_in,
   input logic [NUM_CH-1:0]             evt,
   input logic                          reg_rd,
   input logic [ADDR_W-1:0]             reg_addr,
   input logic [WORD_W-1:0]             reg_rdata,
   input logic [NUM_CH-1:0]             pending,
   input logic [NUM_CH-1:0]             en_vec,
   input logic [NUM_CH-1:0][TIME_W-1:0] stamps
);
   localparam int CH_W = ADDR_W - 2;

   // R10: word select 3 always reads zero
   a_r10_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && reg_addr[1:0] == 2'd3) |=> (reg_rdata == '0));

   for (genvar c = 0; c < NUM_CH; c++) begin : g_p
      logic hi_read;
      assign hi_read = reg_rd && (reg_addr == {CH_W'(c), 2'd2});

      // R3
      a_r3_capture: assert property (@(posedge clk) disable iff (!rst_n)
         (en_vec[c] && evt[c] && !pending[c] && !hi_read)
         |=> (pending[c] && stamps[c] == $past(time_in)));

      // R4
      a_r4_locked: assert property (@(posedge clk) disable iff (!rst_n)
         (pending[c] && !hi_read) |=> (pending[c] && $stable(stamps[c])));

      // R5 and R7
      a_r5_unlock: assert property (@(posedge clk) disable iff (!rst_n)
         hi_read |=> !pending[c]);

      // R8
      a_r8_disabled_idle: assert property (@(posedge clk) disable iff (!rst_n)
         (!en_vec[c] && !pending[c]) |=> !pending[c]);
   end
endmodule

bind pkt_stamp_latch pkt_stamp_latch_chk #(
   .TIME_W(TIME_W), .WORD_W(WORD_W), .NUM_CH(NUM_CH), .ADDR_W(ADDR_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .time_in  (time_in),
   .evt      (evt),
   .reg_rd   (reg_rd),
   .reg_addr (reg_addr),
   .reg_rdata(reg_rdata),
   .pending  (pending),
   .en_vec   (en_vec),
   .stamps   (stamps)
);

// File: tb/pkt_stamp_latch_test.sv
`timescale 1ns/1ps
module pkt_stamp_latch_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] time_in = '0;
   logic [1:0]  evt = '0;
   logic        reg_wr = 1'b0;
   logic        reg_rd = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [1:0]  pending;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   // bench view of each channel, built from the requirements
   bit          m_en    [2];
   bit          m_valid [2];
   logic [63:0] m_stamp [2];
   logic [31:0] m_rdata;

   always #2.5 clk = ~clk;

   pkt_stamp_latch uut (
      .clk(clk), .rst_n(rst_n), .time_in(time_in), .evt(evt),
      .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pending(pending)
   );

   function automatic logic [31:0] exp_word(input logic [3:0] a);
      int ch = int'(a[3:2]);
      if (ch >= 2) return '0;
      case (a[1:0])
         2'd0:    return {30'b0, m_valid[ch], m_en[ch]};
         2'd1:    return m_stamp[ch][31:0];
         2'd2:    return m_stamp[ch][63:32];
         default: return '0;
      endcase
   endfunction

   task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic cycle(input bit wr, input bit rd, input logic [3:0] a,
                        input logic [31:0] wd, input logic [1:0] ev, input string req);
      reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = wd; evt = ev;
      time_in = {$urandom(), $urandom()};
      @(posedge clk);
      if (rd) m_rdata = exp_word(a);
      for (int c = 0; c < 2; c++) begin
         bit hi  = rd && (a == 4'(c * 4 + 2));
         bit wrc = wr && (a == 4'(c * 4));
         if (hi) m_valid[c] = 0;
         else if (m_en[c] && ev[c] && !m_valid[c]) begin
            m_valid[c] = 1;
            m_stamp[c] = time_in;
         end
         if (wrc) m_en[c] = wd[0];
      end
      @(negedge clk);
      reg_wr = 0; reg_rd = 0; evt = '0;
      check32({req, " pending"}, {30'b0, pending}, {30'b0, m_valid[1], m_valid[0]});
      if (rd) check32({req, " rdata"}, reg_rdata, m_rdata);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      for (int c = 0; c < 2; c++) begin m_en[c] = 0; m_valid[c] = 0; m_stamp[c] = '0; end
      m_rdata = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      check32("R1 rdata", reg_rdata, 32'h0);
      check32("R1 pending", {30'b0, pending}, 32'h0);
      cycle(0, 1, 4'd0, 0, 2'b00, "R1 ctrl0");
      cycle(0, 1, 4'd6, 0, 2'b00, "R1 hi1");
      // R8 disabled channel ignores event
      cycle(0, 0, 4'd0, 0, 2'b01, "R8 off");
      // R3 enable receive channel and capture
      cycle(1, 0, 4'd0, 32'h1, 2'b00, "R2 en");
      cycle(0, 0, 4'd0, 0, 2'b01, "R3 capture");
      // R2 control word shows enable and valid; write to valid bit ignored
      cycle(0, 1, 4'd0, 0, 2'b00, "R2 ctrl");
      cycle(1, 0, 4'd0, 32'h1, 2'b00, "R2 wr valid");
      cycle(0, 1, 4'd0, 0, 2'b00, "R2 ctrl after");
      // R4 further events ignored
      cycle(0, 0, 4'd0, 0, 2'b01, "R4 locked");
      // R6 low read keeps lock
      cycle(0, 1, 4'd1, 0, 2'b01, "R6 lo");
      // R5 high read unlocks
      cycle(0, 1, 4'd2, 0, 2'b00, "R5 hi");
      // R7 event same edge as hi read is dropped
      cycle(0, 0, 4'd0, 0, 2'b01, "R7 setup");
      cycle(0, 1, 4'd2, 0, 2'b01, "R7 collide");
      cycle(0, 1, 4'd0, 0, 2'b00, "R7 ctrl");
      // R8 disable keeps pending stamp
      cycle(0, 0, 4'd0, 0, 2'b01, "R8 cap");
      cycle(1, 0, 4'd0, 32'h0, 2'b00, "R8 disable");
      cycle(0, 1, 4'd0, 0, 2'b00, "R8 ctrl");
      cycle(0, 1, 4'd2, 0, 2'b01, "R8 drain");
      cycle(0, 0, 4'd0, 0, 2'b01, "R8 off evt");
      // R9 transmit channel independent
      cycle(1, 0, 4'd4, 32'h1, 2'b00, "R9 tx en");
      cycle(0, 0, 4'd0, 0, 2'b11, "R9 tx cap");
      cycle(0, 1, 4'd1, 0, 2'b00, "R9 rx lo");
      cycle(0, 1, 4'd5, 0, 2'b00, "R9 tx lo");
      cycle(0, 1, 4'd6, 0, 2'b00, "R9 tx hi");
      // R10 reserved word and missing channel read zero
      cycle(0, 1, 4'd7, 0, 2'b00, "R10 rsvd");
      cycle(0, 1, 4'd9, 0, 2'b00, "R10 nochan");
      // random phase: R3/R4/R5/R7/R9 mixed
      for (int i = 0; i < 4000; i++) begin
         logic [3:0] a = 4'($urandom_range(0, 9));
         bit wr = ($urandom_range(0, 9) == 0);
         bit rd = ($urandom_range(0, 1) == 1);
         logic [1:0] ev = {($urandom_range(0, 2) == 0), ($urandom_range(0, 2) == 0)};
         cycle(wr, rd, a, $urandom(), ev, "R3/R4/R5/R7/R9 rand");
      end
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule